// File: doc/BRIEF.md
# Coarse-to-Fine Disparity Refinement Stage

This block is one finer level of a multi-resolution stereo matcher. It takes two rectified grey-level images, a reference view and a scan view, as a pixel-pair stream in raster order. On a separate stream it takes the coarse disparity map that the next coarser level produced for the same frame. For every full-resolution pixel it doubles the coarse estimate of the enclosing 2x2 block and tests three candidate shifts around that value. The shift whose window gives the lowest zero-mean sum of absolute differences becomes the refined disparity.

While pixels arrive, the block also emits a half-resolution copy of both views, each 2x2 block averaged, so the coarser level can be fed from the same stream. Incoming rows stay in on-chip storage until the coarse results that cover them have arrived. Matching then proceeds in raster order at one result per clock for as long as its data is present.

Top module: `zsad_refine`

## Requirements
- R1: The cost of a candidate d at pixel (x,y) is the sum, over a WIN x WIN window centred on (x,y), of |(r - mr) - (s - ms)|. Here r is the reference pixel, s is the scan pixel in the same row at column + d, and mr and ms are the window means. Each mean is the window sum plus N/2, integer-divided by N = WIN*WIN.
- R2: The coarse value c for pixel (x,y) is the entry at coarse position (x/2, y/2). The candidates are 2c-1, 2c and 2c+1, each clamped into [0, DMAX].
- R3: The output is the candidate with the lowest cost. On equal costs the smallest candidate value wins.
- R4: Window rows and columns outside the image take the nearest border pixel. A scan column beyond W-1 takes column W-1.
- R5: Disparities leave on dv_valid/dv_disp in raster order. The result for row y is produced only after pixel row min(y+WIN/2, H-1) and coarse row y/2 have been fully received. It then follows at one result per clock, registered, so it appears one clock after those conditions hold.
- R6: When a pixel pair at an odd column and an odd row is accepted, ds_valid rises on the next clock. ds_ref and ds_scan then carry (a+b+c+d+2)/4 of that 2x2 block for each view.
- R7: frame_done is high for exactly the clock of the frame's last disparity. After it the block accepts a new frame from pixel (0,0) and coarse entry (0,0).
- R8: During and right after reset, dv_valid, ds_valid and frame_done are low.
- R9: dv_disp never exceeds DMAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| px_valid | input | 1 | A pixel pair is present |
| px_ref | input | PW | Reference view pixel |
| px_scan | input | PW | Scan view pixel |
| cd_valid | input | 1 | A coarse disparity is present |
| cd_disp | input | DW | Coarse disparity, raster order over (W/2)x(H/2) |
| ds_valid | output | 1 | Half-resolution pixel pair valid |
| ds_ref | output | PW | Averaged reference pixel |
| ds_scan | output | PW | Averaged scan pixel |
| dv_valid | output | 1 | Refined disparity valid |
| dv_disp | output | DW | Refined disparity |
| frame_done | output | 1 | Last disparity of the frame |

## Verification
The half-resolution output is due exactly one clock after its odd/odd pixel is accepted. The bench notes each such acceptance at a falling edge and expects ds_valid and the averaged values at the very next falling edge. Disparities are due one clock after both their pixel rows and their coarse row are in. The bench holds back coarse rows and confirms that nothing comes out. It then releases one coarse row and counts exactly the two image rows that this unlocks. Every disparity is compared by raster position against a cost model computed in the bench.

// File: rtl/zsad_pkg.sv
package zsad_pkg;
   function automatic int clampi(int v, int hi);
      return (v < 0) ? 0 : ((v > hi) ? hi : v);
   endfunction
endpackage

// File: rtl/zsad_cost.sv
module zsad_cost #(
   parameter int PW = 8,
   parameter int N  = 9,
   parameter int CW = 14
) (
   input  logic [PW-1:0] ref_win [N],
   input  logic [PW-1:0] scn_win [N],
   output logic [CW-1:0] cost
);
   always_comb begin
      int sr, ss, mr, ms, acc, dlt;
      sr = 0;
      ss = 0;
      for (int i = 0; i < N; i++) begin
         sr += int'(ref_win[i]);
         ss += int'(scn_win[i]);
      end
      mr  = (sr + N / 2) / N;
      ms  = (ss + N / 2) / N;
      acc = 0;
      for (int i = 0; i < N; i++) begin
         dlt  = (int'(ref_win[i]) - mr) - (int'(scn_win[i]) - ms);
         acc += (dlt < 0) ? -dlt : dlt;
      end
      cost = CW'(acc);
   end
endmodule

// File: rtl/pix_down2.sv
module pix_down2 #(
   parameter int PW = 8
) (
   input  logic [PW-1:0] a,
   input  logic [PW-1:0] b,
   input  logic [PW-1:0] c,
   input  logic [PW-1:0] d,
   output logic [PW-1:0] avg
);
   logic [PW+1:0] sum;
   assign sum = {2'b00, a} + {2'b00, b} + {2'b00, c} + {2'b00, d} + (PW+2)'(2);
   assign avg = sum[PW+1:2];
endmodule

// File: rtl/zsad_refine.sv
module zsad_refine #(
   parameter int W    = 16,
   parameter int H    = 8,
   parameter int PW   = 8,
   parameter int WIN  = 3,
   parameter int DMAX = 7,
   localparam int DW  = $clog2(DMAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          px_valid,
   input  logic [PW-1:0] px_ref,
   input  logic [PW-1:0] px_scan,
   input  logic          cd_valid,
   input  logic [DW-1:0] cd_disp,
   output logic          ds_valid,
   output logic [PW-1:0] ds_ref,
   output logic [PW-1:0] ds_scan,
   output logic          dv_valid,
   output logic [DW-1:0] dv_disp,
   output logic          frame_done
);
   import zsad_pkg::*;

   localparam int R    = WIN / 2;
   localparam int N    = WIN * WIN;
   localparam int NPIX = W * H;
   localparam int CWID = W / 2;
   localparam int NCD  = CWID * (H / 2);
   localparam int AW   = $clog2(NPIX);
   localparam int CAW  = $clog2(NCD);
   localparam int CW   = PW + 2 + $clog2(N);
   localparam int NC   = 3;

   generate
      if (WIN < 1 || WIN % 2 == 0) begin : g_bad_win
         $error("WIN must be odd and positive");
      end
      if (W < 2 || H < 2 || W % 2 != 0 || H % 2 != 0) begin : g_bad_dim
         $error("W and H must be even and at least 2");
      end
      if (DMAX < 1) begin : g_bad_dmax
         $error("DMAX must be at least 1");
      end
   endgenerate

   logic [PW-1:0] ref_mem [NPIX];
   logic [PW-1:0] scn_mem [NPIX];
   logic [DW-1:0] cd_mem  [NCD];

   int   wr_x, wr_y, cd_x, cd_y, cx, cy;
   logic wr_done, cd_done;
   logic px_take, cd_take;

   assign px_take = px_valid && !wr_done;
   assign cd_take = cd_valid && !cd_done;

   // frame storage: holds rows until coarse data for them is present
   always_ff @(posedge clk) begin
      if (px_take) begin
         ref_mem[AW'(wr_y * W + wr_x)] <= px_ref;
         scn_mem[AW'(wr_y * W + wr_x)] <= px_scan;
      end
      if (cd_take) cd_mem[CAW'(cd_y * CWID + cd_x)] <= cd_disp;
   end

   // half-resolution path
   logic [PW-1:0] dsr_avg, dss_avg;
   logic [AW-1:0] a_ul, a_up, a_lf;
   assign a_ul = AW'((wr_y - 1) * W + wr_x - 1);
   assign a_up = AW'((wr_y - 1) * W + wr_x);
   assign a_lf = AW'(wr_y * W + wr_x - 1);

   pix_down2 #(.PW(PW)) u_dn_ref (.a(ref_mem[a_ul]), .b(ref_mem[a_up]),
                                  .c(ref_mem[a_lf]), .d(px_ref), .avg(dsr_avg));
   pix_down2 #(.PW(PW)) u_dn_scn (.a(scn_mem[a_ul]), .b(scn_mem[a_up]),
                                  .c(scn_mem[a_lf]), .d(px_scan), .avg(dss_avg));

   // matching readiness and window gathering
   int            need_row, coarse, best;
   int            cand [NC];
   logic          fire, last;
   logic [PW-1:0] rwin [N];
   logic [PW-1:0] swin [NC][N];
   logic [CW-1:0] cost [NC];
   logic [CW-1:0] best_cost;

   always_comb begin
      int row, col;
      need_row = (cy + R > H - 1) ? H - 1 : cy + R;
      fire     = (wr_done || wr_y > need_row) && (cd_done || cd_y > cy / 2);
      last     = (cx == W - 1) && (cy == H - 1);
      coarse   = int'(cd_mem[CAW'((cy / 2) * CWID + cx / 2)]);
      for (int k = 0; k < NC; k++) cand[k] = clampi(2 * coarse - 1 + k, DMAX);
      for (int i = 0; i < N; i++) begin
         row     = clampi(cy + i / WIN - R, H - 1);
         col     = clampi(cx + i % WIN - R, W - 1);
         rwin[i] = ref_mem[AW'(row * W + col)];
         for (int k = 0; k < NC; k++)
            swin[k][i] = scn_mem[AW'(row * W + clampi(col + cand[k], W - 1))];
      end
   end

   generate
      for (genvar k = 0; k < NC; k++) begin : g_cost
         zsad_cost #(.PW(PW), .N(N), .CW(CW)) u_cost (
            .ref_win(rwin), .scn_win(swin[k]), .cost(cost[k]));
      end
   endgenerate

   // strict compare keeps the lowest candidate on ties
   always_comb begin
      best      = cand[0];
      best_cost = cost[0];
      for (int k = 1; k < NC; k++) begin
         if (cost[k] < best_cost) begin
            best      = cand[k];
            best_cost = cost[k];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_x <= 0; wr_y <= 0; wr_done <= 1'b0;
         cd_x <= 0; cd_y <= 0; cd_done <= 1'b0;
         cx <= 0; cy <= 0;
         ds_valid <= 1'b0; ds_ref <= '0; ds_scan <= '0;
         dv_valid <= 1'b0; dv_disp <= '0; frame_done <= 1'b0;
      end else begin
         ds_valid <= px_take && wr_x[0] && wr_y[0];
         if (px_take && wr_x[0] && wr_y[0]) begin
            ds_ref  <= dsr_avg;
            ds_scan <= dss_avg;
         end
         if (px_take) begin
            if (wr_x == W - 1) begin
               wr_x <= 0;
               wr_y <= wr_y + 1;
               if (wr_y == H - 1) wr_done <= 1'b1;
            end else wr_x <= wr_x + 1;
         end
         if (cd_take) begin
            if (cd_x == CWID - 1) begin
               cd_x <= 0;
               cd_y <= cd_y + 1;
               if (cd_y == H / 2 - 1) cd_done <= 1'b1;
            end else cd_x <= cd_x + 1;
         end
         dv_valid   <= fire;
         frame_done <= fire && last;
         if (fire) begin
            dv_disp <= DW'(best);
            if (cx == W - 1) begin
               cx <= 0;
               cy <= cy + 1;
            end else cx <= cx + 1;
         end
         if (fire && last) begin
            wr_x <= 0; wr_y <= 0; wr_done <= 1'b0;
            cd_x <= 0; cd_y <= 0; cd_done <= 1'b0;
            cx <= 0; cy <= 0;
         end
      end
   end
endmodule

// File: rtl/zsad_refine_chk.sv
module zsad_refine_chk #(
   parameter int DW   = 3,
   parameter int DMAX = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          px_valid,
   input logic          ds_valid,
   input logic          dv_valid,
   input logic [DW-1:0] dv_disp,
   input logic          frame_done
);
   AST_DISP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      dv_valid |-> (int'(dv_disp) <= DMAX));                    // R9
   AST_DS_AFTER_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
      ds_valid |-> $past(px_valid));                            // R6
   AST_DS_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      ds_valid |=> !ds_valid);                                  // R6
   AST_DONE_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> dv_valid);                                 // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);                              // R7
   AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
      !rst_n |=> (!dv_valid && !ds_valid && !frame_done));      // R8
endmodule

bind zsad_refine zsad_refine_chk #(.DW(DW), .DMAX(DMAX)) u_chk (
   .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .ds_valid(ds_valid),
   .dv_valid(dv_valid), .dv_disp(dv_disp), .frame_done(frame_done));

// File: tb/tb_zsad_refine.sv
module tb_zsad_refine;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16, H = 8, PW = 8, WIN = 3, DMAX = 7;
   localparam int DW = $clog2(DMAX + 1);
   localparam int NPIX = W * H, NCD = (W / 2) * (H / 2), N = WIN * WIN, R = WIN / 2;

   logic clk = 0, rst_n = 0;
   logic px_valid = 0, cd_valid = 0;
   logic [PW-1:0] px_ref = '0, px_scan = '0;
   logic [DW-1:0] cd_disp = '0;
   logic ds_valid, dv_valid, frame_done;
   logic [PW-1:0] ds_ref, ds_scan;
   logic [DW-1:0] dv_disp;

   int n_chk = 0, n_bad = 0, dv_n = 0, fd_n = 0, mon_px = 0, cyc = 0;
   int ref_a [NPIX], scn_a [NPIX], cd_a [NCD], got [NPIX];
   logic pend = 0;
   int   pend_pos = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   zsad_refine #(.W(W), .H(H), .PW(PW), .WIN(WIN), .DMAX(DMAX)) dut (
      .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_ref(px_ref), .px_scan(px_scan),
      .cd_valid(cd_valid), .cd_disp(cd_disp), .ds_valid(ds_valid), .ds_ref(ds_ref),
      .ds_scan(ds_scan), .dv_valid(dv_valid), .dv_disp(dv_disp), .frame_done(frame_done));

   function automatic int cl(int v, int hi);
      return (v < 0) ? 0 : ((v > hi) ? hi : v);
   endfunction

   // bench model of R1..R4
   function automatic int exp_disp(int x, int y);
      int c, bestd, bestc, d, sr, ss, mr, ms, cst, rv, sv, t;
      c = cd_a[(y / 2) * (W / 2) + x / 2];
      bestd = 0; bestc = -1;
      for (int k = -1; k <= 1; k++) begin
         d = cl(2 * c + k, DMAX);
         sr = 0; ss = 0;
         for (int dy = -R; dy <= R; dy++)
            for (int dx = -R; dx <= R; dx++) begin
               sr += ref_a[cl(y + dy, H - 1) * W + cl(x + dx, W - 1)];
               ss += scn_a[cl(y + dy, H - 1) * W + cl(cl(x + dx, W - 1) + d, W - 1)];
            end
         mr = (sr + N / 2) / N; ms = (ss + N / 2) / N; cst = 0;
         for (int dy = -R; dy <= R; dy++)
            for (int dx = -R; dx <= R; dx++) begin
               rv = ref_a[cl(y + dy, H - 1) * W + cl(x + dx, W - 1)];
               sv = scn_a[cl(y + dy, H - 1) * W + cl(cl(x + dx, W - 1) + d, W - 1)];
               t = (rv - mr) - (sv - ms);
               cst += (t < 0) ? -t : t;
            end
         if (bestc < 0 || cst < bestc) begin bestc = cst; bestd = d; end
      end
      return bestd;
   endfunction

   function automatic int exp_ds(int p, bit scan);
      int x, y, s;
      x = p % W; y = p / W;
      if (scan) s = scn_a[(y-1)*W+x-1] + scn_a[(y-1)*W+x] + scn_a[y*W+x-1] + scn_a[y*W+x];
      else      s = ref_a[(y-1)*W+x-1] + ref_a[(y-1)*W+x] + ref_a[y*W+x-1] + ref_a[y*W+x];
      return (s + 2) / 4;
   endfunction

   task automatic chk(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // output monitor, sampling at the falling edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (pend) begin
            chk(ds_valid == 1'b1, "R6 ds_valid latency", int'(ds_valid), 1);
            chk(int'(ds_ref) == exp_ds(pend_pos, 0), "R6 ds_ref", int'(ds_ref), exp_ds(pend_pos, 0));
            chk(int'(ds_scan) == exp_ds(pend_pos, 1), "R6 ds_scan", int'(ds_scan), exp_ds(pend_pos, 1));
         end else if (ds_valid) chk(1'b0, "R6 spurious ds_valid", 1, 0);
         pend = 0;
         if (px_valid) begin
            pend_pos = mon_px % NPIX;
            pend = ((pend_pos % W) % 2 == 1) && ((pend_pos / W) % 2 == 1);
            mon_px++;
         end
         if (dv_valid) begin
            got[dv_n % NPIX] = int'(dv_disp);
            if (frame_done) chk(dv_n % NPIX == NPIX - 1, "R7 done position", dv_n % NPIX, NPIX - 1);
            dv_n++;
         end
         if (frame_done) fd_n++;
      end
   end

   task automatic drive_pixels();
      for (int i = 0; i < NPIX; i++) begin
         @(posedge clk); #1;
         px_valid = 1; px_ref = PW'(ref_a[i]); px_scan = PW'(scn_a[i]);
      end
      @(posedge clk); #1; px_valid = 0;
   endtask

   task automatic drive_coarse(int r0, int r1, int gap);
      for (int i = r0 * (W / 2); i < r1 * (W / 2); i++) begin
         repeat (gap) @(posedge clk);
         #1; cd_valid = 1; cd_disp = DW'(cd_a[i]);
         @(posedge clk); #1; cd_valid = 0;
      end
   endtask

   task automatic wait_dv(int target);
      while (dv_n < target) @(negedge clk);
   endtask

   task automatic check_frame(string req, int base);
      for (int i = 0; i < NPIX; i++)
         chk(got[i] == exp_disp(i % W, i / W), req, got[i], exp_disp(i % W, i / W));
      chk(fd_n == base + 1, "R7 one frame_done", fd_n, base + 1);
   endtask

   function automatic int tex(int x, int y);
      return (x * x * 7 + x * 29 + y * 13 + x * y * 3) % 256;
   endfunction

   // R1 R4 R6: textured views shifted by 4, coarse 2 everywhere
   task automatic t_shift();
      int b, f;
      for (int i = 0; i < NPIX; i++) begin
         ref_a[i] = tex(i % W, i / W);
         scn_a[i] = tex(cl(i % W - 4, W - 1), i / W);
      end
      for (int i = 0; i < NCD; i++) cd_a[i] = 2;
      b = dv_n; f = fd_n;
      fork drive_pixels(); drive_coarse(0, H / 2, 1); join
      wait_dv(b + NPIX);
      check_frame("R1 R4 shifted match", f);
      chk(got[5 * W + 6] == 4, "R1 interior disparity", got[5 * W + 6], 4);
   endtask

   // R5: held-back coarse rows gate the results
   task automatic t_sync();
      int b, f;
      for (int i = 0; i < NPIX; i++) begin
         ref_a[i] = tex(i / W, i % W);
         scn_a[i] = tex(cl(i % W - 2, W - 1) / 1, i / W) ^ (i % 5);
      end
      for (int i = 0; i < NCD; i++) cd_a[i] = (i * 3) % 4;
      b = dv_n; f = fd_n;
      drive_pixels();
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(dv_n == b, "R5 no result without coarse", dv_n - b, 0);
      drive_coarse(0, 1, 0);
      repeat (3 * W) @(posedge clk);
      @(negedge clk);
      chk(dv_n - b == 2 * W, "R5 one coarse row unlocks two rows", dv_n - b, 2 * W);
      drive_coarse(1, H / 2, 0);
      wait_dv(b + NPIX);
      check_frame("R5 gated frame values", f);
   endtask

   // R2 R3: flat images give equal costs, clamped low candidate wins
   task automatic t_flat();
      int b, f;
      for (int i = 0; i < NPIX; i++) begin ref_a[i] = 100; scn_a[i] = 100; end
      for (int i = 0; i < NCD; i++) cd_a[i] = ((i % (W / 2)) % 3 == 0) ? 0 : (((i % (W / 2)) % 3 == 1) ? 3 : 7);
      b = dv_n; f = fd_n;
      fork drive_pixels(); drive_coarse(0, H / 2, 0); join
      wait_dv(b + NPIX);
      check_frame("R3 tie frame", f);
      chk(got[0] == 0, "R2 low clamp tie", got[0], 0);
      chk(got[2] == 5, "R3 tie picks 2c-1", got[2], 5);
      chk(got[4] == 7, "R2 high clamp", got[4], 7);
      for (int i = 0; i < NPIX; i++) chk(got[i] <= DMAX, "R9 range", got[i], DMAX);
   endtask

   // R1: brightness offset on scan view is removed by the zero-mean terms
   task automatic t_offset();
      int b, f;
      for (int i = 0; i < NPIX; i++) begin
         ref_a[i] = tex(i % W, i / W) / 2;
         scn_a[i] = tex(cl(i % W - 3, W - 1), i / W) / 2 + 40;
      end
      for (int i = 0; i < NCD; i++) cd_a[i] = (i % (W / 2) + i / (W / 2)) % 4;
      b = dv_n; f = fd_n;
      fork drive_pixels(); drive_coarse(0, H / 2, 2); join
      wait_dv(b + NPIX);
      check_frame("R1 offset frame", f);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", cyc, 0);
      summary();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(!dv_valid && !ds_valid && !frame_done, "R8 reset state",
          int'(dv_valid) + int'(ds_valid) + int'(frame_done), 0);
      @(posedge clk); #1; rst_n = 1;
      repeat (2) @(negedge clk);
      chk(!dv_valid && !ds_valid && !frame_done, "R8 idle after reset",
          int'(dv_valid) + int'(ds_valid) + int'(frame_done), 0);
      t_shift();
      t_sync();
      t_flat();
      t_offset();
      repeat (5) @(posedge clk);
      summary();
   end
endmodule